// File: doc/BRIEF.md
# Counted Blocking Channel Bank

This block sits between a processor core and its communication controller. It offers a set of numbered 32-bit message channels. Each channel has one fixed direction as seen from the core, either read-only or write-only. Each channel also has a fixed blocking attribute and a small capacity counter that says how many more transfers may still be outstanding. The core issues a read or a write by channel number. An access that the block accepts lowers that channel's count by one. The controller raises the count again by pulsing a per-channel completion line, and for inbound channels that pulse also loads fresh read data.

A blocking channel whose count is zero holds the core on a stall line until the controller completes an action on it. A non-blocking channel never stalls. An access to a channel number that does not exist, or an access in the wrong direction, ends at once with an error flag. The core can also ask for the current count of any channel through a separate query strobe.

Top module: `chan_bank`

## Requirements
- R1: After reset every write channel holds a count of 1, every read channel and every absent channel holds 0, and all registered outputs are zero.
- R2: An accepted write to a present write channel raises exactly bit `ch` of `ctl_wr_valid` for one cycle, one cycle after acceptance, with the write data on `ctl_wr_data`. The channel's count drops by one.
- R3: Writes to channels 19 and 20 forward only bits 15:0 of the data. Bits 31:16 of `ctl_wr_data` are zero.
- R4: An accepted read of a present read channel returns, one cycle later on `core_rdata` with `core_ack` high, the data most recently loaded by that channel's completion pulse, and lowers the channel's count by one.
- R5: A completion pulse raises the channel's count by one. The count stops at CNT_MAX (4 by default). Pulses on absent channels have no effect.
- R6: While the core requests a blocking channel (0, 3, 4, 9, 21, 23, 24, 25, 27, 28, 29, 30) in its legal direction and that channel's count is 0, `core_stall` is high in the same cycle. The access completes in the first cycle in which the count is nonzero.
- R7: An access to a non-blocking channel at count 0 does not stall, and the count stays at 0.
- R8: An accepted access and a completion pulse on the same channel in the same cycle leave its count unchanged.
- R9: An access to an absent channel (5, 6, 10, 31), a write to a read channel (0, 3, 4, 8, 11, 12, 13, 15, 24, 25, 27, 29) or a read of a write channel never stalls. One cycle later it gives `core_ack` and `core_err` high, `core_rdata` zero and no write strobe, and the count is unchanged.
- R10: A query strobe loads the count of channel `core_ch`, as it stands in that cycle, onto `cnt_value` one cycle later. An absent channel reads as 0. Without a strobe, `cnt_value` holds its value.
- R11: `core_stall` is low whenever no request is present, and whenever the request does not meet the conditions of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core channel access request |
| core_wr | input | 1 | 1 = channel write, 0 = channel read |
| core_ch | input | 5 | Channel number, for accesses and for count queries |
| core_wdata | input | 32 | Write data |
| core_stall | output | 1 | Core must hold the request; the access is not taken this cycle |
| core_ack | output | 1 | An access completed in the previous cycle |
| core_err | output | 1 | The completed access was illegal |
| core_rdata | output | 32 | Read data of the completed access |
| cnt_query | input | 1 | Count query strobe |
| cnt_value | output | 3 | Count returned by the last query |
| ctl_done | input | 32 | Per-channel completion pulse from the controller |
| ctl_rd_data | input | 1024 | Per-channel inbound data, 32 bits per channel, channel c in bits 32c+31:32c |
| ctl_wr_valid | output | 32 | One-hot strobe of a forwarded write |
| ctl_wr_data | output | 32 | Forwarded write data |

## Verification
The properties take for granted that the core keeps its request, channel number and direction unchanged for as long as `core_stall` is high. The controller's completion pulses may arrive on any channel in any cycle. The bench meets the first condition by repeating a stalled request unchanged in the following cycle, and it often adds a completion pulse on the stalled channel so that every stall ends. Completion pulses, inbound data, channel numbers and directions are otherwise drawn freely, so absent channels and wrong-direction accesses come up often.

// File: rtl/chan_pkg.sv
package chan_pkg;

    // Default channel attributes, one bit per channel number.
    localparam logic [31:0] DEF_PRESENT = 32'h7FFF_FB9F;
    localparam logic [31:0] DEF_READ    = 32'h2B00_B919;
    localparam logic [31:0] DEF_BLOCK   = 32'h7BA0_0219;
    localparam logic [31:0] DEF_NARROW  = 32'h0018_0000;

    // Outcome of a core access in the current cycle.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_OK   = 2'd1,
        ACC_BAD  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/chan_access_ctrl.sv
module chan_access_ctrl
    import chan_pkg::*;
#(
    parameter int               NUM_CH       = 32,
    parameter int               CH_W         = 5,
    parameter logic [NUM_CH-1:0] PRESENT_MASK = '0,
    parameter logic [NUM_CH-1:0] READ_MASK    = '0,
    parameter logic [NUM_CH-1:0] BLOCK_MASK   = '0
) (
    input  logic              core_req,
    input  logic              core_wr,
    input  logic [CH_W-1:0]   core_ch,
    input  logic [NUM_CH-1:0] cnt_zero,
    output logic              stall,
    output acc_kind_e         acc_kind,
    output logic [NUM_CH-1:0] issue_vec
);

    logic dir_ok;
    logic wait_cnt;

    always_comb begin
        // Legal only if the channel exists and the direction matches.
        dir_ok   = PRESENT_MASK[core_ch] && (core_wr != READ_MASK[core_ch]);
        wait_cnt = dir_ok && BLOCK_MASK[core_ch] && cnt_zero[core_ch];
        stall    = core_req && wait_cnt;

        acc_kind  = ACC_NONE;
        issue_vec = '0;
        if (core_req && !wait_cnt) begin
            if (dir_ok) begin
                acc_kind           = ACC_OK;
                issue_vec[core_ch] = 1'b1;
            end else begin
                acc_kind = ACC_BAD;
            end
        end
    end

endmodule

// File: rtl/chan_slot.sv
module chan_slot #(
    parameter int DATA_W   = 32,
    parameter int CNT_MAX  = 4,
    parameter int INIT_CNT = 0,
    parameter bit PRESENT  = 1'b1,
    parameter bit IS_READ  = 1'b0,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DATA_W-1:0] data_o
);

    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_CNT);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t s_d, s_q;
    logic  done_eff;

    always_comb begin
        s_d      = s_q;
        done_eff = done_i && PRESENT;

        if (issue_i && !done_eff) begin
            // Floor at zero: a non-blocking access at zero leaves it there.
            if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
        end else if (done_eff && !issue_i) begin
            if (s_q.cnt != CNT_TOP) s_d.cnt = s_q.cnt + 1'b1;
        end

        if (done_eff && IS_READ) s_d.data = push_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= CNT_INIT;
            s_q.data <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign data_o = s_q.data;

endmodule

// File: rtl/chan_resp.sv
module chan_resp
    import chan_pkg::*;
#(
    parameter int               NUM_CH      = 32,
    parameter int               CH_W        = 5,
    parameter int               DATA_W      = 32,
    parameter int               CNT_W       = 3,
    parameter int               NARROW_W    = 16,
    parameter logic [NUM_CH-1:0] NARROW_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         acc_kind,
    input  logic              core_wr,
    input  logic [CH_W-1:0]   core_ch,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] sel_data,
    input  logic              cnt_query,
    input  logic [CNT_W-1:0]  sel_cnt,
    output logic              core_ack,
    output logic              core_err,
    output logic [DATA_W-1:0] core_rdata,
    output logic [NUM_CH-1:0] ctl_wr_valid,
    output logic [DATA_W-1:0] ctl_wr_data,
    output logic [CNT_W-1:0]  cnt_value
);

    localparam logic [DATA_W-1:0] LOW_KEEP =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [NUM_CH-1:0] wr_vld;
        logic [DATA_W-1:0] wr_data;
        logic [CNT_W-1:0]  cnt;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.ack     = (acc_kind != ACC_NONE);
        r_d.err     = (acc_kind == ACC_BAD);
        r_d.rdata   = '0;
        r_d.wr_vld  = '0;
        r_d.wr_data = '0;

        if (acc_kind == ACC_OK) begin
            if (core_wr) begin
                r_d.wr_vld[core_ch] = 1'b1;
                r_d.wr_data = NARROW_MASK[core_ch] ? (core_wdata & LOW_KEEP)
                                                   : core_wdata;
            end else begin
                r_d.rdata = sel_data;
            end
        end

        if (cnt_query) r_d.cnt = sel_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign core_ack     = r_q.ack;
    assign core_err     = r_q.err;
    assign core_rdata   = r_q.rdata;
    assign ctl_wr_valid = r_q.wr_vld;
    assign ctl_wr_data  = r_q.wr_data;
    assign cnt_value    = r_q.cnt;

endmodule

// File: rtl/chan_bank.sv
module chan_bank
    import chan_pkg::*;
#(
    parameter int                NUM_CH       = 32,
    parameter int                DATA_W       = 32,
    parameter int                CNT_MAX      = 4,
    parameter int                WR_INIT      = 1,
    parameter int                RD_INIT      = 0,
    parameter int                NARROW_W     = 16,
    parameter logic [NUM_CH-1:0] PRESENT_MASK = NUM_CH'(DEF_PRESENT),
    parameter logic [NUM_CH-1:0] READ_MASK    = NUM_CH'(DEF_READ),
    parameter logic [NUM_CH-1:0] BLOCK_MASK   = NUM_CH'(DEF_BLOCK),
    parameter logic [NUM_CH-1:0] NARROW_MASK  = NUM_CH'(DEF_NARROW),
    localparam int               CH_W         = $clog2(NUM_CH),
    localparam int               CNT_W        = $clog2(CNT_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     core_req,
    input  logic                     core_wr,
    input  logic [CH_W-1:0]          core_ch,
    input  logic [DATA_W-1:0]        core_wdata,
    output logic                     core_stall,
    output logic                     core_ack,
    output logic                     core_err,
    output logic [DATA_W-1:0]        core_rdata,
    input  logic                     cnt_query,
    output logic [CNT_W-1:0]         cnt_value,
    input  logic [NUM_CH-1:0]        ctl_done,
    input  logic [NUM_CH*DATA_W-1:0] ctl_rd_data,
    output logic [NUM_CH-1:0]        ctl_wr_valid,
    output logic [DATA_W-1:0]        ctl_wr_data
);

    logic [NUM_CH-1:0]       cnt_zero;
    logic [NUM_CH-1:0]       issue_vec;
    logic [NUM_CH*CNT_W-1:0] cnt_flat;
    logic [CNT_W-1:0]        slot_cnt  [NUM_CH];
    logic [DATA_W-1:0]       slot_data [NUM_CH];
    logic [CNT_W-1:0]        sel_cnt;
    logic [DATA_W-1:0]       sel_data;
    acc_kind_e               acc_kind;

    chan_access_ctrl #(
        .NUM_CH       (NUM_CH),
        .CH_W         (CH_W),
        .PRESENT_MASK (PRESENT_MASK),
        .READ_MASK    (READ_MASK),
        .BLOCK_MASK   (BLOCK_MASK)
    ) u_ctrl (
        .core_req  (core_req),
        .core_wr   (core_wr),
        .core_ch   (core_ch),
        .cnt_zero  (cnt_zero),
        .stall     (core_stall),
        .acc_kind  (acc_kind),
        .issue_vec (issue_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        localparam int SLOT_INIT = PRESENT_MASK[g] ? (READ_MASK[g] ? RD_INIT : WR_INIT) : 0;

        chan_slot #(
            .DATA_W   (DATA_W),
            .CNT_MAX  (CNT_MAX),
            .INIT_CNT (SLOT_INIT),
            .PRESENT  (PRESENT_MASK[g]),
            .IS_READ  (READ_MASK[g])
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue_i     (issue_vec[g]),
            .done_i      (ctl_done[g]),
            .push_data_i (ctl_rd_data[g*DATA_W +: DATA_W]),
            .cnt_o       (slot_cnt[g]),
            .data_o      (slot_data[g])
        );

        assign cnt_zero[g]                 = (slot_cnt[g] == '0);
        assign cnt_flat[g*CNT_W +: CNT_W]  = slot_cnt[g];
    end

    always_comb begin
        sel_cnt  = slot_cnt[core_ch];
        sel_data = slot_data[core_ch];
    end

    chan_resp #(
        .NUM_CH      (NUM_CH),
        .CH_W        (CH_W),
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .NARROW_W    (NARROW_W),
        .NARROW_MASK (NARROW_MASK)
    ) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_kind     (acc_kind),
        .core_wr      (core_wr),
        .core_ch      (core_ch),
        .core_wdata   (core_wdata),
        .sel_data     (sel_data),
        .cnt_query    (cnt_query),
        .sel_cnt      (sel_cnt),
        .core_ack     (core_ack),
        .core_err     (core_err),
        .core_rdata   (core_rdata),
        .ctl_wr_valid (ctl_wr_valid),
        .ctl_wr_data  (ctl_wr_data),
        .cnt_value    (cnt_value)
    );

endmodule

// File: rtl/chan_bank_chk.sv
module chan_bank_chk #(
    parameter int NUM_CH  = 32,
    parameter int CH_W    = 5,
    parameter int CNT_W   = 3,
    parameter int CNT_MAX = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     core_req,
    input logic                     core_wr,
    input logic [CH_W-1:0]          core_ch,
    input logic                     core_stall,
    input logic                     core_ack,
    input logic                     core_err,
    input logic [NUM_CH-1:0]        ctl_wr_valid,
    input logic [NUM_CH*CNT_W-1:0]  cnt_flat
);

    // R6: a stalled cycle produces no completion in the next cycle.
    a_r6_no_ack_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> !core_ack);

    // R6: input rule - the core keeps its request steady while stalled.
    a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> (core_req && $stable(core_ch) && $stable(core_wr)));

    // R2: a request that is not stalled is acknowledged one cycle later.
    a_r2_ack_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_stall) |=> core_ack);

    // R2: at most one write strobe per cycle.
    a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_wr_valid));

    // R9: an error is always a completed access.
    a_r9_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        core_err |-> core_ack);

    // R9: an illegal access forwards no write.
    a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        core_err |-> (ctl_wr_valid == '0));

    // R11: no stall without a request.
    a_r11_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> core_req);

    // R5: every count stays within its limit.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
        a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[g*CNT_W +: CNT_W] <= CNT_W'(CNT_MAX));
    end

endmodule

bind chan_bank chan_bank_chk #(
    .NUM_CH  (NUM_CH),
    .CH_W    (CH_W),
    .CNT_W   (CNT_W),
    .CNT_MAX (CNT_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_req     (core_req),
    .core_wr      (core_wr),
    .core_ch      (core_ch),
    .core_stall   (core_stall),
    .core_ack     (core_ack),
    .core_err     (core_err),
    .ctl_wr_valid (ctl_wr_valid),
    .cnt_flat     (cnt_flat)
);

// File: tb/sim_chan_bank.sv
module sim_chan_bank;

    localparam int NCH  = 32;
    localparam int DW   = 32;
    localparam int CMAX = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              core_req = 1'b0;
    logic              core_wr = 1'b0;
    logic [4:0]        core_ch = '0;
    logic [DW-1:0]     core_wdata = '0;
    logic              core_stall, core_ack, core_err;
    logic [DW-1:0]     core_rdata;
    logic              cnt_query = 1'b0;
    logic [2:0]        cnt_value;
    logic [NCH-1:0]    ctl_done = '0;
    logic [NCH*DW-1:0] ctl_rd_data = '0;
    logic [NCH-1:0]    ctl_wr_valid;
    logic [DW-1:0]     ctl_wr_data;

    always #5 clk = ~clk;

    chan_bank u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_wr(core_wr),
        .core_ch(core_ch), .core_wdata(core_wdata), .core_stall(core_stall),
        .core_ack(core_ack), .core_err(core_err), .core_rdata(core_rdata),
        .cnt_query(cnt_query), .cnt_value(cnt_value), .ctl_done(ctl_done),
        .ctl_rd_data(ctl_rd_data), .ctl_wr_valid(ctl_wr_valid),
        .ctl_wr_data(ctl_wr_data)
    );

    int checks = 0;
    int errors = 0;
    int          m_cnt [NCH];
    logic [31:0] m_mem [NCH];
    logic [2:0]  m_cv;

    function automatic bit f_present(int c);
        return !(c == 5 || c == 6 || c == 10 || c == 31);
    endfunction

    function automatic bit f_read(int c);
        case (c)
            0, 3, 4, 8, 11, 12, 13, 15, 24, 25, 27, 29: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit f_block(int c);
        case (c)
            0, 3, 4, 9, 21, 23, 24, 25, 27, 28, 29, 30: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit f_narrow(int c);
        return (c == 19 || c == 20);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive, check stall, update model, check registered outputs.
    task automatic step(input bit req, input bit wr, input int ch, input logic [31:0] wd,
                        input logic [31:0] done, input bit query, input string tag,
                        output bit stalled);
        bit          valid, e_stall, acc, e_ack, e_err;
        logic [31:0] e_rdata, e_wrd;
        logic [31:0] e_wrv;
        string       t;
        @(negedge clk);
        core_req   = req;
        core_wr    = wr;
        core_ch    = 5'(ch);
        core_wdata = wd;
        ctl_done   = done;
        cnt_query  = query;
        for (int i = 0; i < NCH; i++) ctl_rd_data[i*DW +: DW] = $urandom;
        #1;
        valid   = f_present(ch) && (wr != f_read(ch));
        e_stall = req && valid && f_block(ch) && (m_cnt[ch] == 0);
        acc     = req && !e_stall;
        t = (tag != "") ? tag : (e_stall ? "R6" : "R11");
        chk(core_stall == e_stall, t, "stall", 64'(core_stall), 64'(e_stall));

        e_ack   = acc;
        e_err   = acc && !valid;
        e_rdata = (acc && valid && !wr) ? m_mem[ch] : 32'h0;
        e_wrv   = (acc && valid && wr) ? (32'h1 << ch) : 32'h0;
        e_wrd   = (acc && valid && wr) ? (f_narrow(ch) ? (wd & 32'hFFFF) : wd) : 32'h0;
        if (query) m_cv = f_present(ch) ? 3'(m_cnt[ch]) : 3'd0;

        for (int c = 0; c < NCH; c++) begin
            bit iss, dn;
            iss = acc && valid && (ch == c);
            dn  = done[c] && f_present(c);
            if (iss && !dn)      m_cnt[c] = (m_cnt[c] > 0) ? m_cnt[c] - 1 : 0;
            else if (dn && !iss) m_cnt[c] = (m_cnt[c] < CMAX) ? m_cnt[c] + 1 : CMAX;
            if (dn && f_read(c)) m_mem[c] = ctl_rd_data[c*DW +: DW];
        end

        @(posedge clk);
        #1;
        if (tag != "") t = tag;
        else if (e_err) t = "R9";
        else if (e_wrv != 0) t = f_narrow(ch) ? "R3" : "R2";
        else t = "R4";
        chk(core_ack == e_ack, t, "ack", 64'(core_ack), 64'(e_ack));
        chk(core_err == e_err, t, "err", 64'(core_err), 64'(e_err));
        chk(core_rdata == e_rdata, t, "rdata", 64'(core_rdata), 64'(e_rdata));
        chk(ctl_wr_valid == e_wrv, t, "wr_valid", 64'(ctl_wr_valid), 64'(e_wrv));
        chk(ctl_wr_data == e_wrd, t, "wr_data", 64'(ctl_wr_data), 64'(e_wrd));
        t = (tag != "") ? tag : "R10";
        chk(cnt_value == m_cv, t, "cnt_value", 64'(cnt_value), 64'(m_cv));
        stalled = e_stall;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit st;
        bit h_req, h_wr, h_q;
        int h_ch;
        logic [31:0] h_wd, dn;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = (f_present(c) && !f_read(c)) ? 1 : 0;
            m_mem[c] = 32'h0;
        end
        m_cv = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: registered outputs are zero after reset
        chk(core_ack == 1'b0 && core_err == 1'b0, "R1", "ack/err", 64'({core_ack, core_err}), 64'h0);
        chk(ctl_wr_valid == '0, "R1", "wr_valid", 64'(ctl_wr_valid), 64'h0);
        chk(cnt_value == '0, "R1", "cnt_value", 64'(cnt_value), 64'h0);
        // R1: initial counts through queries
        step(0, 0, 1, 0, 0, 1, "R1", st);
        step(0, 0, 29, 0, 0, 1, "R1", st);
        step(0, 0, 6, 0, 0, 1, "R1", st);
        step(0, 0, 22, 0, 0, 1, "R1", st);
        // R3: narrow channels
        step(1, 1, 19, 32'hDEAD_BEEF, 0, 0, "R3", st);
        step(1, 1, 20, 32'h1234_5678, 0, 0, "R3", st);
        step(1, 1, 17, 32'hCAFE_F00D, 0, 0, "R2", st);
        // R7: non-blocking read at zero
        step(1, 0, 8, 0, 0, 0, "R7", st);
        step(0, 0, 8, 0, 0, 1, "R7", st);
        // R6: blocking read at zero stalls until a completion arrives
        step(1, 0, 29, 0, 0, 0, "R6", st);
        step(1, 0, 29, 0, 0, 0, "R6", st);
        step(1, 0, 29, 0, 32'h1 << 29, 0, "R6", st);
        step(1, 0, 29, 0, 0, 0, "R6", st);
        step(0, 0, 29, 0, 0, 1, "R6", st);
        // R8: access and completion in the same cycle
        step(1, 1, 16, 32'h55AA_55AA, 32'h1 << 16, 1, "R8", st);
        step(0, 0, 16, 0, 0, 1, "R8", st);
        // R5: saturation
        for (int k = 0; k < 6; k++) step(0, 0, 16, 0, 32'h1 << 16, 0, "R5", st);
        step(0, 0, 16, 0, 0, 1, "R5", st);
        step(0, 0, 31, 0, 32'h8000_0000, 1, "R5", st);
        step(0, 0, 31, 0, 0, 1, "R5", st);
        // R9: illegal accesses
        step(1, 1, 0, 32'hFFFF_FFFF, 0, 0, "R9", st);
        step(1, 0, 5, 0, 0, 0, "R9", st);
        step(1, 0, 22, 0, 0, 0, "R9", st);
        step(1, 1, 31, 32'h1, 0, 1, "R9", st);
        // R11: no stall when idle on a blocking channel at zero
        step(0, 0, 24, 0, 0, 0, "R11", st);

        // Random phase
        st = 1'b0;
        h_req = 0; h_wr = 0; h_ch = 0; h_wd = 0; h_q = 0;
        for (int n = 0; n < 3000; n++) begin
            dn = $urandom & $urandom & $urandom;
            if (st) begin
                if ($urandom_range(0, 1) == 1) dn = dn | (32'h1 << h_ch);
            end else begin
                h_req = ($urandom_range(0, 3) != 0);
                h_wr  = $urandom_range(0, 1) == 1;
                h_ch  = $urandom_range(0, 31);
                h_wd  = $urandom;
            end
            h_q = $urandom_range(0, 2) == 0;
            step(h_req, h_wr, h_ch, h_wd, dn, h_q, "", st);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule